// File: doc/BRIEF.md
# Programmable Counter Array

This block is one free-running 16-bit counter that serves a set of identical capture/compare channels. The counter advances by one on each clock in which both the run bit and the prescaled count-enable input are high. Each channel holds its own mode byte and a 16-bit compare/capture pair. The mode byte turns the channel into one of four units:

- an edge capture unit that copies the counter when its external input changes;
- a software timer that raises a flag on a 16-bit match;
- a high-speed output that also toggles its pin on each match;
- an 8-bit pulse-width modulator.

Software reaches every register through one byte-wide port. The address map is fixed:

- 0: counter low byte.
- 1: counter high byte.
- 2: channel flags, write 1 to clear.
- 3: counter-overflow flag in bit 0, write 1 to clear.
- Channel n starts at 4+4n. Its offsets are +0 mode, +1 compare low, +2 compare high and +3 PWM extension bits. In the extension register, bit 0 is the active extension and bit 1 is the reload extension.

Each channel is a small state machine, and its state comes from the mode byte.

States:
- IDLE: nothing enabled.
- CAPTURE: bit 6 is clear and bit 5 or bit 4 is set. Bit 5 selects the rising edge and bit 4 the falling edge.
- SWTIMER: bits 6 and 3 are set and bits 2 and 1 are clear.
- HSOUT: bits 6, 3 and 2 are set and bit 1 is clear.
- PWM: bits 6 and 1 are set.

Transitions: the only transition is a write to the channel's mode register. It moves the channel from any state to the state decoded from the written byte. No event inside the block changes the state.

In PWM mode the pin is low while the counter low byte is below the 9-bit duty {active extension, compare low}, and high otherwise. When the counter low byte wraps from 0xFF, the compare high byte and the reload extension bit are copied into the active duty. This keeps duty updates glitch-free.

Top module: `pca_array`

## Requirements
- R1: After reset the counter, all compare pairs, mode bytes, flags, pins and interrupt outputs are zero.
- R2: The counter increments by one on every clock with run and cnt_en both high, and holds otherwise. A write to address 0 or 1 loads that byte and suppresses the increment in that cycle.
- R3: A counting step from 0xFFFF to 0x0000 sets the overflow flag (address 3 bit 0). The flag stays set until software writes 1 to bit 0 of address 3.
- R4: In capture mode (mode 0x20 rising, 0x10 falling, 0x30 both), a selected edge on ext_in copies the counter into the compare pair on the third clock edge after the input changes, and sets the channel flag. An edge that is not selected changes neither the pair nor the flag.
- R5: In software-timer mode (0x48), a counting step taken while the counter equals the compare pair sets the channel flag and leaves the pin unchanged.
- R6: In high-speed output mode (0x4C), each such matching counting step also toggles the channel pin. A counting step without a match leaves the pin unchanged.
- R7: In PWM mode (0x42), the pin is 0 while {0, counter[7:0]} < {active extension, compare[7:0]}, and 1 otherwise.
- R8: In PWM mode, a counting step from counter low byte 0xFF loads compare[15:8] into compare[7:0] and the reload extension into the active extension.
- R9: Writing 1 to bit n of address 2 clears the flag of channel n. A set event in the same cycle wins.
- R10: mod_irq[n] is high when channel n's flag is set and bit 0 of its mode byte is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter run bit |
| cnt_en | input | 1 | Prescaled count-enable pulse |
| ext_in | input | NUM_CH | Per-channel external inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mod_pin | output | NUM_CH | Per-channel output pins |
| mod_flag | output | NUM_CH | Per-channel event flags |
| mod_irq | output | NUM_CH | Per-channel enabled interrupt requests |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
The assertions check the counter on every cycle:
- it holds when not counting and steps by one when counting;
- the overflow flag sets on a wrap;
- the overflow flag stays set until it is cleared, and clears on a write of 1.

The per-channel behaviour is shown only by the bench's scenarios. This covers the synchronizer latency on captures, edge selection, match timing, pin toggling, the PWM threshold including the ninth duty bit, and the duty reload at the low-byte wrap.

// File: rtl/pca_pkg.sv
package pca_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_SWTIMER,
        ST_HSOUT,
        ST_PWM
    } ch_state_e;

    localparam int CW        = 16;
    localparam int B_CMPEN   = 6;
    localparam int B_RISE    = 5;
    localparam int B_FALL    = 4;
    localparam int B_MATCH   = 3;
    localparam int B_TOGGLE  = 2;
    localparam int B_PWM     = 1;
    localparam int B_IRQEN   = 0;

    function automatic ch_state_e decode_mode(input logic [6:0] m);
        ch_state_e s;
        if (m[B_CMPEN] && m[B_PWM])                          s = ST_PWM;
        else if (m[B_CMPEN] && m[B_MATCH] && m[B_TOGGLE])    s = ST_HSOUT;
        else if (m[B_CMPEN] && m[B_MATCH])                   s = ST_SWTIMER;
        else if (!m[B_CMPEN] && (m[B_RISE] || m[B_FALL]))    s = ST_CAPTURE;
        else                                                 s = ST_IDLE;
        return s;
    endfunction

endpackage

// File: rtl/pca_counter.sv
module pca_counter
    import pca_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_req,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [7:0]    ld_data,
    output logic [CW-1:0] cnt,
    output logic          full_wrap,
    output logic          low_wrap
);
    logic step;

    assign step      = step_req && !ld_lo && !ld_hi;
    assign full_wrap = step && (&cnt);
    assign low_wrap  = step && (&cnt[7:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt[7:0]    <= ld_data;
            if (ld_hi) cnt[15:8]   <= ld_data;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;
endmodule

// File: rtl/pca_channel.sv
module pca_channel
    import pca_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] cnt,
    input  logic          low_wrap,
    input  logic          rise,
    input  logic          fall,
    input  logic          wr_mode,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          wr_ext,
    input  logic [7:0]    wdata,
    input  logic          flag_clr,
    output logic [6:0]    mode,
    output logic [CW-1:0] cmp,
    output logic [1:0]    ext,
    output logic          flag,
    output logic          pin,
    output logic          irq
);
    ch_state_e st_q, st_d;
    logic      tog_q;
    logic      cap_hit, match_hit, reload, pwm_level;

    // state register
    always_comb begin
        st_d = st_q;
        if (wr_mode) st_d = decode_mode(wdata[6:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            mode <= '0;
        end else begin
            st_q <= st_d;
            if (wr_mode) mode <= wdata[6:0];
        end
    end

    // event decode per state
    always_comb begin
        cap_hit   = 1'b0;
        match_hit = 1'b0;
        reload    = 1'b0;
        unique case (st_q)
            ST_CAPTURE: cap_hit   = (mode[B_RISE] && rise) || (mode[B_FALL] && fall);
            ST_SWTIMER,
            ST_HSOUT:   match_hit = step && (cnt == cmp);
            ST_PWM:     reload    = low_wrap;
            ST_IDLE:    ;
            default:    ;
        endcase
    end

    assign pwm_level = !({1'b0, cnt[7:0]} < {ext[0], cmp[7:0]});

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp   <= '0;
            ext   <= '0;
            flag  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            if (cap_hit) begin
                cmp <= cnt;
            end else begin
                if (wr_lo)       cmp[7:0] <= wdata;
                else if (reload) cmp[7:0] <= cmp[15:8];
                if (wr_hi)       cmp[15:8] <= wdata;
            end
            if (wr_ext) begin
                ext <= wdata[1:0];
            end else if (reload) begin
                ext[0] <= ext[1];
            end
            if (cap_hit || match_hit) flag <= 1'b1;
            else if (flag_clr)        flag <= 1'b0;
            if (match_hit && st_q == ST_HSOUT) tog_q <= ~tog_q;
        end
    end

    // outputs per state
    always_comb begin
        unique case (st_q)
            ST_PWM:  pin = pwm_level;
            default: pin = tog_q;
        endcase
    end

    assign irq = flag && mode[B_IRQEN];
endmodule

// File: rtl/pca_array.sv
module pca_array
    import pca_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cnt_en,
    input  logic [NUM_CH-1:0] ext_in,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] mod_pin,
    output logic [NUM_CH-1:0] mod_flag,
    output logic [NUM_CH-1:0] mod_irq,
    output logic              ovf_flag
);
    localparam int A_CNTLO = 0;
    localparam int A_CNTHI = 1;
    localparam int A_FLAGS = 2;
    localparam int A_OVF   = 3;
    localparam int CH_BASE = 4;
    localparam int CH_SPAN = 4;

    logic [CW-1:0]     cnt_q;
    logic              full_wrap, low_wrap, step_req, ld_lo, ld_hi, ovf_clr;
    logic [NUM_CH-1:0] rise, fall;
    logic [6:0]        mode_a [NUM_CH];
    logic [CW-1:0]     cmp_a  [NUM_CH];
    logic [1:0]        ext_a  [NUM_CH];

    assign step_req = run && cnt_en;
    assign ld_lo    = reg_wr && (reg_addr == AW'(A_CNTLO));
    assign ld_hi    = reg_wr && (reg_addr == AW'(A_CNTHI));
    assign ovf_clr  = reg_wr && (reg_addr == AW'(A_OVF)) && reg_wdata[0];

    pca_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .ld_data   (reg_wdata),
        .cnt       (cnt_q),
        .full_wrap (full_wrap),
        .low_wrap  (low_wrap)
    );

    pca_edge_sync #(.N(NUM_CH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_in),
        .rise  (rise),
        .fall  (fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_flag <= 1'b0;
        else if (full_wrap) ovf_flag <= 1'b1;
        else if (ovf_clr)   ovf_flag <= 1'b0;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = CH_BASE + CH_SPAN * g;
        logic w_mode, w_lo, w_hi, w_ext, f_clr;
        assign w_mode = reg_wr && (reg_addr == AW'(BASE));
        assign w_lo   = reg_wr && (reg_addr == AW'(BASE + 1));
        assign w_hi   = reg_wr && (reg_addr == AW'(BASE + 2));
        assign w_ext  = reg_wr && (reg_addr == AW'(BASE + 3));
        assign f_clr  = reg_wr && (reg_addr == AW'(A_FLAGS)) && reg_wdata[g];

        pca_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step_req && !ld_lo && !ld_hi),
            .cnt      (cnt_q),
            .low_wrap (low_wrap),
            .rise     (rise[g]),
            .fall     (fall[g]),
            .wr_mode  (w_mode),
            .wr_lo    (w_lo),
            .wr_hi    (w_hi),
            .wr_ext   (w_ext),
            .wdata    (reg_wdata),
            .flag_clr (f_clr),
            .mode     (mode_a[g]),
            .cmp      (cmp_a[g]),
            .ext      (ext_a[g]),
            .flag     (mod_flag[g]),
            .pin      (mod_pin[g]),
            .irq      (mod_irq[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(A_CNTLO)) reg_rdata = cnt_q[7:0];
        if (reg_addr == AW'(A_CNTHI)) reg_rdata = cnt_q[15:8];
        if (reg_addr == AW'(A_FLAGS)) reg_rdata = 8'(mod_flag);
        if (reg_addr == AW'(A_OVF))   reg_rdata = {7'd0, ovf_flag};
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == AW'(CH_BASE + CH_SPAN * i))     reg_rdata = {1'b0, mode_a[i]};
            if (reg_addr == AW'(CH_BASE + CH_SPAN * i + 1)) reg_rdata = cmp_a[i][7:0];
            if (reg_addr == AW'(CH_BASE + CH_SPAN * i + 2)) reg_rdata = cmp_a[i][15:8];
            if (reg_addr == AW'(CH_BASE + CH_SPAN * i + 3)) reg_rdata = {6'd0, ext_a[i]};
        end
    end
endmodule

// File: rtl/pca_array_chk.sv
module pca_array_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          cnt_en,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic          wbit0,
    input logic [15:0]   count,
    input logic          ovf_flag
);
    logic cnt_ld, stepping, wrapping, clr_ovf;

    assign cnt_ld   = reg_wr && (reg_addr == AW'(0) || reg_addr == AW'(1));
    assign stepping = run && cnt_en && !cnt_ld;
    assign wrapping = stepping && (count == 16'hFFFF);
    assign clr_ovf  = reg_wr && (reg_addr == AW'(3)) && wbit0;

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && cnt_en) && !cnt_ld) |=> $stable(count));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |=> (count == 16'($past(count) + 16'd1)));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrapping |=> ovf_flag);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    p_ovf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !wrapping) |=> !ovf_flag);
endmodule

bind pca_array pca_array_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cnt_en   (cnt_en),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0]),
    .count    (cnt_q),
    .ovf_flag (ovf_flag)
);

// File: tb/pca_array_tb_top.sv
`timescale 1ns/1ps
module pca_array_tb_top;
    localparam int NCH = 4;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run = 1'b0;
    logic           cnt_en = 1'b0;
    logic [NCH-1:0] ext_in = '0;
    logic           reg_wr = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] mod_pin, mod_flag, mod_irq;
    logic           ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pca_array #(.NUM_CH(NCH), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(cnt_en), .ext_in(ext_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mod_pin(mod_pin), .mod_flag(mod_flag),
        .mod_irq(mod_irq), .ovf_flag(ovf_flag)
    );

    // {ext, duty, counter low, expected pin}
    localparam logic [17:0] PWM_VEC [8] = '{
        {1'b0, 8'h80, 8'h7F, 1'b0},
        {1'b0, 8'h80, 8'h80, 1'b1},
        {1'b0, 8'h00, 8'h00, 1'b1},
        {1'b1, 8'h00, 8'hFF, 1'b0},
        {1'b0, 8'hFF, 8'hFE, 1'b0},
        {1'b0, 8'hFF, 8'hFF, 1'b1},
        {1'b0, 8'h40, 8'h10, 1'b0},
        {1'b0, 8'h40, 8'hC0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        run = 1'b1; cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(0, v[7:0]);
        wr(1, v[15:8]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); chk("R1 cnt lo", v, 0);
        rd(5, v); chk("R1 cmp lo", v, 0);
        rd(4, v); chk("R1 mode", v, 0);
        chk("R1 pins", mod_pin, 0);
        chk("R1 flags", {mod_irq, mod_flag, 7'd0, ovf_flag}, 0);

        // R2 counting
        ticks(5);
        rd(0, v); chk("R2 five steps", v, 5);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R2 hold cnt_en low", v, 5);
        run = 1'b0; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en = 1'b0;
        rd(0, v); chk("R2 hold run low", v, 5);

        // R3 overflow
        set_cnt(16'hFFFE);
        run = 1'b0;
        ticks(1);
        chk("R3 no ovf before wrap", ovf_flag, 0);
        ticks(1);
        rd(0, v); rd(1, h);
        chk("R3 wrapped value", {h, v}, 0);
        chk("R3 ovf set", ovf_flag, 1);
        wr(3, 8'h00);
        chk("R3 write 0 keeps ovf", ovf_flag, 1);
        wr(3, 8'h01);
        rd(3, v); chk("R3 ovf cleared", v, 0);
        run = 1'b0;

        // R7 PWM level table on channel 0
        wr(4, 8'h42);
        for (int i = 0; i < 8; i++) begin
            wr(7, {7'd0, PWM_VEC[i][17]});
            wr(5, PWM_VEC[i][16:9]);
            wr(0, PWM_VEC[i][8:1]);
            #1 chk($sformatf("R7 vec %0d", i), mod_pin[0], PWM_VEC[i][0]);
        end

        // R8 reload at low byte wrap
        wr(6, 8'h80); wr(7, 8'h00); wr(5, 8'h10);
        set_cnt(16'h00FF);
        #1 chk("R7 before reload", mod_pin[0], 1);
        ticks(1);
        run = 1'b0;
        rd(5, v); chk("R8 duty reloaded", v, 8'h80);
        #1 chk("R8 pin after reload", mod_pin[0], 0);
        wr(6, 8'h00); wr(7, 8'h02);
        set_cnt(16'h00FF);
        ticks(1);
        run = 1'b0;
        rd(7, v); chk("R8 ext reloaded", v, 8'h03);

        // R4 capture on channel 1
        wr(8, 8'h20);
        set_cnt(16'h1234);
        @(negedge clk); ext_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd(9, v); rd(10, h);
        chk("R4 rising capture", {h, v}, 16'h1234);
        chk("R4 flag set", mod_flag[1], 1);
        wr(2, 8'h02);
        chk("R9 flag cleared", mod_flag[1], 0);
        set_cnt(16'h5555);
        @(negedge clk); ext_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd(9, v); chk("R4 falling ignored value", v, 8'h34);
        chk("R4 falling ignored flag", mod_flag[1], 0);
        wr(8, 8'h30);
        set_cnt(16'h00AB);
        @(negedge clk); ext_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd(9, v); chk("R4 both edges rise", v, 8'hAB);
        set_cnt(16'h00CD);
        @(negedge clk); ext_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd(9, v); chk("R4 both edges fall", v, 8'hCD);

        // R5 software timer on channel 2
        wr(12, 8'h48); wr(13, 8'h10); wr(14, 8'h00);
        wr(2, 8'hFF);
        set_cnt(16'h000E);
        ticks(2);
        run = 1'b0;
        chk("R5 no flag before match", mod_flag[2], 0);
        ticks(1);
        run = 1'b0;
        chk("R5 flag on match", mod_flag[2], 1);
        chk("R5 pin unchanged", mod_pin[2], 0);
        chk("R10 irq masked", mod_irq[2], 0);
        wr(12, 8'h49);
        chk("R10 irq enabled", mod_irq[2], 1);
        wr(2, 8'h04);
        chk("R9 other flag kept", {mod_flag[2], mod_flag[1]}, 2'b00);

        // R6 high-speed output on channel 3
        wr(16, 8'h4C); wr(17, 8'h20); wr(18, 8'h00);
        set_cnt(16'h0020);
        ticks(1);
        run = 1'b0;
        chk("R6 toggle high", mod_pin[3], 1);
        set_cnt(16'h0020);
        ticks(1);
        run = 1'b0;
        chk("R6 toggle low", mod_pin[3], 0);
        set_cnt(16'h0030);
        ticks(1);
        run = 1'b0;
        chk("R6 no match no toggle", mod_pin[3], 0);

        finish_run();
    end
endmodule